// File: doc/BRIEF.md
# Bidirectional Cluster Ring With Arrival Queues

This block joins a set of execution clusters in a bidirectional ring. Each cluster owns one node. A node may inject a result value in any cycle, as long as the outgoing link in the chosen direction is not already carrying a message that is passing through. The source picks the shorter way around the ring. When the two ways are equally long, it picks clockwise. Each hop takes one cycle. Messages that pass through a node are never stored there: they go straight onto the next link, and they win over any local injection that wants the same link.

A message going clockwise and one going counter-clockwise can reach the same destination in the same cycle. Each node therefore keeps a small arrival queue. The queue takes up to two entries per cycle and hands one entry per cycle to the cluster's single register-file write port. There is no flow control between links. If an arrival would overflow the queue, the node instead moves from state `ST_RUN` to state `ST_FLUSH` (transition "overflow") and raises a pipeline-flush request. The request stays high until the cluster acknowledges it. The acknowledge empties the queue and moves the node from `ST_FLUSH` back to `ST_RUN` (transition "acknowledge"). In every other case each state holds.

Top module: `aring_fabric`

## Requirements
- R1: While reset is held and in the first cycle after it, with no injection requested, `wp_valid`, `flush_req` and `inj_ready` are all zero.
- R2: An injection at node s is accepted (`inj_ready[s]`=1, combinationally in the same cycle) exactly when `inj_valid[s]`=1, the destination is a different node, and the outgoing link in the chosen direction carries no message passing through node s in that cycle.
- R3: An injection whose destination equals the source node is refused (`inj_ready`=0), and it is never delivered at any write port.
- R4: Let g = (dst - src) mod NODES. The message goes clockwise (index +1 per hop) when g <= NODES/2, otherwise counter-clockwise, so h = min(g, NODES-g) hops. It appears on `wp_valid[dst]` / `wp_data[dst]` in the cycle that follows the h-th rising edge after the accepting edge, and it appears at no other node.
- R5: A message passing through a node takes that node's outgoing link ahead of a local injection in the same direction. The injection is refused that cycle and can be accepted in the next free cycle.
- R6: When a clockwise arrival (from node dst-1) and a counter-clockwise arrival (from node dst+1) reach a node in the same cycle, both are queued, and the clockwise one is delivered first.
- R7: While in `ST_RUN`, the write port presents the oldest queued entry whenever the queue is non-empty and drains one entry per cycle in arrival order.
- R8: The queue holds DEPTH entries (default 8). If the entries after a cycle (current minus one read plus arrivals) would exceed DEPTH, every arrival of that cycle is dropped, the read still happens, and `flush_req` is 1 from the next cycle.
- R9: In `ST_FLUSH`, `flush_req` stays 1 until `flush_ack`, the write port stays idle and arrivals are discarded.
- R10: `flush_ack` in `ST_FLUSH` empties the queue and returns to `ST_RUN`, so `flush_req` and `wp_valid` are 0 in the following cycle. `flush_ack` in `ST_RUN` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | NODES | Per-node injection request |
| inj_dest | input | NODES*ID_W | Per-node destination index |
| inj_data | input | NODES*DATA_W | Per-node value to send |
| inj_ready | output | NODES | Injection accepted this cycle |
| wp_valid | output | NODES | Write-port strobe per node |
| wp_data | output | NODES*DATA_W | Write-port value per node |
| flush_req | output | NODES | Sticky pipeline-flush request |
| flush_ack | input | NODES | Flush acknowledge, clears the queue |

## Verification
A sweep sends a lone message over every source and destination pair of a four-node ring. The hop count it measures separates the clockwise, counter-clockwise and self-addressed cases. A directed clash puts a message passing through against a local injection in the same direction. Because this clash only happens if the two-hop tie is resolved clockwise, it also checks the tie-break. A paired arrival at one node shows the dequeue order, and an acknowledge sent while running shows that it has no effect there. A sustained flood from both sides grows the queue by one entry per cycle, so exactly seven deliveries come out before the flush request, which fixes the overflow threshold. The flood is followed by acknowledge, recovery and a fresh message.

// File: rtl/aring_pkg.sv
package aring_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } flush_state_e;

    // clockwise distance from one node index to another on a ring of n nodes
    function automatic logic [31:0] ring_gap(input logic [31:0] from_id,
                                             input logic [31:0] to_id,
                                             input logic [31:0] n);
        return (to_id + n - from_id) % n;
    endfunction

endpackage

// File: rtl/aring_steer.sv
module aring_steer #(
    parameter int NODES = 4,
    parameter int SELF  = 0,
    parameter int ID_W  = 2
) (
    input  logic [ID_W-1:0] dest,
    output logic            dest_ok,
    output logic            go_cw
);
    localparam logic [31:0] N32    = 32'(NODES);
    localparam logic [31:0] SELF32 = 32'(SELF);

    logic [31:0] dest32;
    logic [31:0] gap;

    always_comb begin
        dest32  = 32'(dest);
        gap     = aring_pkg::ring_gap(SELF32, dest32, N32);
        dest_ok = (dest32 < N32) && (dest32 != SELF32);
        go_cw   = (gap <= (N32 >> 1));
    end
endmodule

// File: rtl/aring_link.sv
module aring_link #(
    parameter int ID_W   = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd_vld,
    input  logic [ID_W-1:0]   fwd_dst,
    input  logic [DATA_W-1:0] fwd_dat,
    input  logic              inj_req,
    input  logic [ID_W-1:0]   inj_dst,
    input  logic [DATA_W-1:0] inj_dat,
    output logic              inj_grant,
    output logic              out_vld,
    output logic [ID_W-1:0]   out_dst,
    output logic [DATA_W-1:0] out_dat
);
    // traffic already on the ring owns the link
    assign inj_grant = inj_req && !fwd_vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_dst <= '0;
            out_dat <= '0;
        end else begin
            out_vld <= fwd_vld || inj_req;
            if (fwd_vld) begin
                out_dst <= fwd_dst;
                out_dat <= fwd_dat;
            end else if (inj_req) begin
                out_dst <= inj_dst;
                out_dat <= inj_dat;
            end
        end
    end
endmodule

// File: rtl/aring_qfifo.sv
module aring_qfifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_a,
    input  logic [DATA_W-1:0] dat_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] dat_b,
    input  logic              rd,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  count;
    logic [SUM_W-1:0]  total;
    logic [PTR_W-1:0]  slot_b;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        total  = SUM_W'(count) + SUM_W'(wr_a) + SUM_W'(wr_b) - SUM_W'(rd);
        ovf    = (total > SUM_W'(DEPTH));
        slot_b = wr_a ? bump(wptr) : wptr;
        empty  = (count == '0);
        head   = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (rd) rptr <= bump(rptr);
            if (ovf) begin
                count <= count - CNT_W'(rd);
            end else begin
                count <= total[CNT_W-1:0];
                if (wr_a && wr_b) wptr <= bump(bump(wptr));
                else if (wr_a || wr_b) wptr <= bump(wptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!ovf) begin
            if (wr_a) mem[wptr]   <= dat_a;
            if (wr_b) mem[slot_b] <= dat_b;
        end
    end
endmodule

// File: rtl/aring_flush_fsm.sv
module aring_flush_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic ack,
    output logic running,
    output logic clear,
    output logic flush_req
);
    import aring_pkg::*;

    flush_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (ovf) nxt = ST_FLUSH;
            ST_FLUSH: if (ack) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    always_comb begin
        running   = 1'b0;
        clear     = 1'b0;
        flush_req = 1'b0;
        unique case (state)
            ST_RUN:   running = 1'b1;
            ST_FLUSH: begin
                flush_req = 1'b1;
                clear     = ack;
            end
            default:  running = 1'b0;
        endcase
    end
endmodule

// File: rtl/aring_node.sv
module aring_node #(
    parameter int NODES  = 4,
    parameter int SELF   = 0,
    parameter int ID_W   = 2,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_in_vld,
    input  logic [ID_W-1:0]   cw_in_dst,
    input  logic [DATA_W-1:0] cw_in_dat,
    input  logic              ccw_in_vld,
    input  logic [ID_W-1:0]   ccw_in_dst,
    input  logic [DATA_W-1:0] ccw_in_dat,
    output logic              cw_out_vld,
    output logic [ID_W-1:0]   cw_out_dst,
    output logic [DATA_W-1:0] cw_out_dat,
    output logic              ccw_out_vld,
    output logic [ID_W-1:0]   ccw_out_dst,
    output logic [DATA_W-1:0] ccw_out_dat,
    input  logic              inj_valid,
    input  logic [ID_W-1:0]   inj_dest,
    input  logic [DATA_W-1:0] inj_data,
    output logic              inj_ready,
    output logic              wp_valid,
    output logic [DATA_W-1:0] wp_data,
    output logic              flush_req,
    input  logic              flush_ack
);
    localparam logic [ID_W-1:0] SELF_ID = ID_W'(SELF);

    logic cw_hit, ccw_hit, cw_fwd, ccw_fwd;
    logic dest_ok, go_cw;
    logic cw_req, ccw_req, cw_grant, ccw_grant;
    logic running, clear, ovf, empty, rd;

    // arrival decode: stop here or continue on the same direction
    assign cw_hit  = cw_in_vld  && (cw_in_dst  == SELF_ID);
    assign ccw_hit = ccw_in_vld && (ccw_in_dst == SELF_ID);
    assign cw_fwd  = cw_in_vld  && !cw_hit;
    assign ccw_fwd = ccw_in_vld && !ccw_hit;

    aring_steer #(.NODES(NODES), .SELF(SELF), .ID_W(ID_W)) u_steer (
        .dest    (inj_dest),
        .dest_ok (dest_ok),
        .go_cw   (go_cw)
    );

    assign cw_req    = inj_valid && dest_ok && go_cw;
    assign ccw_req   = inj_valid && dest_ok && !go_cw;
    assign inj_ready = cw_grant || ccw_grant;

    aring_link #(.ID_W(ID_W), .DATA_W(DATA_W)) u_cw (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwd_vld   (cw_fwd),
        .fwd_dst   (cw_in_dst),
        .fwd_dat   (cw_in_dat),
        .inj_req   (cw_req),
        .inj_dst   (inj_dest),
        .inj_dat   (inj_data),
        .inj_grant (cw_grant),
        .out_vld   (cw_out_vld),
        .out_dst   (cw_out_dst),
        .out_dat   (cw_out_dat)
    );

    aring_link #(.ID_W(ID_W), .DATA_W(DATA_W)) u_ccw (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwd_vld   (ccw_fwd),
        .fwd_dst   (ccw_in_dst),
        .fwd_dat   (ccw_in_dat),
        .inj_req   (ccw_req),
        .inj_dst   (inj_dest),
        .inj_dat   (inj_data),
        .inj_grant (ccw_grant),
        .out_vld   (ccw_out_vld),
        .out_dst   (ccw_out_dst),
        .out_dat   (ccw_out_dat)
    );

    assign rd = running && !empty;

    // clockwise arrival takes the earlier queue slot
    aring_qfifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .wr_a  (cw_hit && running),
        .dat_a (cw_in_dat),
        .wr_b  (ccw_hit && running),
        .dat_b (ccw_in_dat),
        .rd    (rd),
        .head  (wp_data),
        .empty (empty),
        .ovf   (ovf)
    );

    aring_flush_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf       (ovf && running),
        .ack       (flush_ack),
        .running   (running),
        .clear     (clear),
        .flush_req (flush_req)
    );

    assign wp_valid = rd;
endmodule

// File: rtl/aring_fabric.sv
module aring_fabric #(
    parameter int NODES  = 4,
    parameter int ID_W   = $clog2(NODES),
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NODES-1:0]         inj_valid,
    input  logic [NODES*ID_W-1:0]    inj_dest,
    input  logic [NODES*DATA_W-1:0]  inj_data,
    output logic [NODES-1:0]         inj_ready,
    output logic [NODES-1:0]         wp_valid,
    output logic [NODES*DATA_W-1:0]  wp_data,
    output logic [NODES-1:0]         flush_req,
    input  logic [NODES-1:0]         flush_ack
);
    // link k leaves node k; cw reaches k+1, ccw reaches k-1
    logic [NODES-1:0]  cw_vld, ccw_vld;
    logic [ID_W-1:0]   cw_dst  [NODES];
    logic [ID_W-1:0]   ccw_dst [NODES];
    logic [DATA_W-1:0] cw_dat  [NODES];
    logic [DATA_W-1:0] ccw_dat [NODES];

    for (genvar i = 0; i < NODES; i++) begin : g_node
        localparam int PREV = (i + NODES - 1) % NODES;
        localparam int NEXT = (i + 1) % NODES;

        aring_node #(
            .NODES  (NODES),
            .SELF   (i),
            .ID_W   (ID_W),
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_node (
            .clk         (clk),
            .rst_n       (rst_n),
            .cw_in_vld   (cw_vld[PREV]),
            .cw_in_dst   (cw_dst[PREV]),
            .cw_in_dat   (cw_dat[PREV]),
            .ccw_in_vld  (ccw_vld[NEXT]),
            .ccw_in_dst  (ccw_dst[NEXT]),
            .ccw_in_dat  (ccw_dat[NEXT]),
            .cw_out_vld  (cw_vld[i]),
            .cw_out_dst  (cw_dst[i]),
            .cw_out_dat  (cw_dat[i]),
            .ccw_out_vld (ccw_vld[i]),
            .ccw_out_dst (ccw_dst[i]),
            .ccw_out_dat (ccw_dat[i]),
            .inj_valid   (inj_valid[i]),
            .inj_dest    (inj_dest[i*ID_W +: ID_W]),
            .inj_data    (inj_data[i*DATA_W +: DATA_W]),
            .inj_ready   (inj_ready[i]),
            .wp_valid    (wp_valid[i]),
            .wp_data     (wp_data[i*DATA_W +: DATA_W]),
            .flush_req   (flush_req[i]),
            .flush_ack   (flush_ack[i])
        );
    end
endmodule

// File: rtl/aring_checker.sv
module aring_checker #(
    parameter int NODES  = 4,
    parameter int ID_W   = 2,
    parameter int DATA_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NODES-1:0]        inj_valid,
    input logic [NODES*ID_W-1:0]   inj_dest,
    input logic [NODES*DATA_W-1:0] inj_data,
    input logic [NODES-1:0]        inj_ready,
    input logic [NODES-1:0]        wp_valid,
    input logic [NODES*DATA_W-1:0] wp_data,
    input logic [NODES-1:0]        flush_req,
    input logic [NODES-1:0]        flush_ack
);
    for (genvar i = 0; i < NODES; i++) begin : g_chk
        AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            inj_ready[i] |-> inj_valid[i]); // R2
        AST_SELF_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
            (inj_valid[i] && inj_dest[i*ID_W +: ID_W] == ID_W'(i)) |-> !inj_ready[i]); // R3
        AST_FLUSH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_req[i] && !flush_ack[i]) |=> flush_req[i]); // R9
        AST_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            flush_req[i] |-> !wp_valid[i]); // R9
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_req[i] && flush_ack[i]) |=> (!flush_req[i] && !wp_valid[i])); // R10
    end
endmodule

bind aring_fabric aring_checker #(.NODES(NODES), .ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inj_valid (inj_valid),
    .inj_dest  (inj_dest),
    .inj_data  (inj_data),
    .inj_ready (inj_ready),
    .wp_valid  (wp_valid),
    .wp_data   (wp_data),
    .flush_req (flush_req),
    .flush_ack (flush_ack)
);

// File: tb/tb_aring_fabric.sv
`timescale 1ns/1ps
module tb_aring_fabric;
    localparam int NODES  = 4;
    localparam int ID_W   = 2;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                    rst_n;
    logic [NODES-1:0]        inj_valid;
    logic [NODES*ID_W-1:0]   inj_dest;
    logic [NODES*DATA_W-1:0] inj_data;
    logic [NODES-1:0]        inj_ready;
    logic [NODES-1:0]        wp_valid;
    logic [NODES*DATA_W-1:0] wp_data;
    logic [NODES-1:0]        flush_req;
    logic [NODES-1:0]        flush_ack;

    aring_fabric #(.NODES(NODES), .ID_W(ID_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .inj_dest(inj_dest),
        .inj_data(inj_data), .inj_ready(inj_ready), .wp_valid(wp_valid),
        .wp_data(wp_data), .flush_req(flush_req), .flush_ack(flush_ack)
    );

    int  n_chk  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic drive(input int n, input logic v, input logic [ID_W-1:0] d,
                         input logic [DATA_W-1:0] x);
        inj_valid[n]                  = v;
        inj_dest[n*ID_W +: ID_W]      = d;
        inj_data[n*DATA_W +: DATA_W]  = x;
    endtask

    function automatic logic [DATA_W-1:0] port_data(input int n);
        return wp_data[n*DATA_W +: DATA_W];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        inj_valid = '0;
        inj_dest  = '0;
        inj_data  = '0;
        flush_ack = '0;
        repeat (3) @(posedge clk);
        settle();
        check("R1", "wp_valid in reset", 32'(wp_valid), 0);
        check("R1", "flush_req in reset", 32'(flush_req), 0);
        tick();
        rst_n = 1'b1;
        settle();
        check("R1", "wp_valid after reset", 32'(wp_valid), 0);
        check("R1", "flush_req after reset", 32'(flush_req), 0);
        check("R1", "inj_ready after reset", 32'(inj_ready), 0);

        // sweep every source / destination pair with one lone message
        for (int src = 0; src < NODES; src++) begin
            for (int dst = 0; dst < NODES; dst++) begin
                int gap, hops;
                logic [DATA_W-1:0] val;
                val  = DATA_W'(16'hA000 | (src << 8) | dst);
                gap  = (dst - src + NODES) % NODES;
                hops = (gap <= NODES / 2) ? gap : NODES - gap;
                tick();
                drive(src, 1'b1, ID_W'(dst), val);
                settle();
                if (src == dst) begin
                    check("R3", "self dest ready", 32'(inj_ready[src]), 0);
                    tick();
                    drive(src, 1'b0, '0, '0);
                    for (int j = 0; j < NODES + 1; j++) begin
                        tick();
                        settle();
                        check("R3", "self dest never delivered", 32'(wp_valid), 0);
                    end
                end else begin
                    check("R2", "ready on free link", 32'(inj_ready[src]), 1);
                    tick();
                    drive(src, 1'b0, '0, '0);
                    for (int j = 1; j <= hops + 1; j++) begin
                        tick();
                        settle();
                        check("R4", "delivery mask by hop",
                              32'(wp_valid), (j == hops) ? (32'd1 << dst) : 32'd0);
                        if (j == hops)
                            check("R4", "delivered data", 32'(port_data(dst)), 32'(val));
                    end
                end
            end
        end

        // R5: passing traffic beats injection; also fixes the tie toward cw
        tick();
        drive(0, 1'b1, 2'd2, 16'h5001);
        settle();
        check("R2", "node0 ready", 32'(inj_ready[0]), 1);
        tick();
        drive(0, 1'b0, '0, '0);
        drive(1, 1'b1, 2'd2, 16'h5101);
        settle();
        check("R5", "injection blocked by forward", 32'(inj_ready[1]), 0);
        tick();
        settle();
        check("R5", "retry accepted", 32'(inj_ready[1]), 1);
        tick();
        drive(1, 1'b0, '0, '0);
        settle();
        check("R5", "through message first", 32'(wp_valid), 32'b0100);
        check("R5", "through data", 32'(port_data(2)), 32'h5001);
        tick();
        settle();
        check("R5", "blocked message next", 32'(wp_valid), 32'b0100);
        check("R5", "blocked data", 32'(port_data(2)), 32'h5101);
        tick();
        settle();
        check("R7", "queue drained", 32'(wp_valid), 0);

        // R6 paired arrival, R10 ack while running ignored
        tick();
        drive(0, 1'b1, 2'd1, 16'h6000);
        drive(2, 1'b1, 2'd1, 16'h6200);
        settle();
        check("R2", "both sides ready", 32'(inj_ready), 32'b0101);
        tick();
        drive(0, 1'b0, '0, '0);
        drive(2, 1'b0, '0, '0);
        flush_ack[1] = 1'b1;
        tick();
        flush_ack[1] = 1'b0;
        settle();
        check("R10", "ack in run no flush", 32'(flush_req), 0);
        check("R6", "first of pair valid", 32'(wp_valid), 32'b0010);
        check("R6", "cw arrival first", 32'(port_data(1)), 32'h6000);
        tick();
        settle();
        check("R6", "second of pair valid", 32'(wp_valid), 32'b0010);
        check("R6", "ccw arrival second", 32'(port_data(1)), 32'h6200);
        tick();
        settle();
        check("R7", "empty after pair", 32'(wp_valid), 0);

        // R7/R8: flood node 1 from both sides, net growth one per cycle
        for (int k = 0; k < 14; k++) begin
            int m;
            m = k - 1;
            tick();
            drive(0, 1'b1, 2'd1, DATA_W'(16'h7000 | k));
            drive(2, 1'b1, 2'd1, DATA_W'(16'h7200 | k));
            settle();
            check("R2", "flood injections ready", 32'(inj_ready & 4'b0101), 32'b0101);
            if (m < 1) begin
                check("R7", "flood port idle at start", 32'(wp_valid), 0);
            end else if (m <= DEPTH - 1) begin
                int idx;
                idx = m - 1;
                check("R7", "flood delivery", 32'(wp_valid), 32'b0010);
                check("R7", "flood order",
                      32'(port_data(1)),
                      32'h7000 | ((idx % 2) ? 32'h200 : 32'h0) | 32'(idx / 2));
                check("R8", "no flush yet", 32'(flush_req), 0);
            end else begin
                check("R8", "flush raised", 32'(flush_req), 32'b0010);
                check("R9", "port idle in flush", 32'(wp_valid), 0);
            end
        end
        tick();
        drive(0, 1'b0, '0, '0);
        drive(2, 1'b0, '0, '0);
        repeat (5) tick();
        settle();
        check("R9", "flush sticky", 32'(flush_req), 32'b0010);
        check("R9", "port still idle", 32'(wp_valid), 0);
        tick();
        flush_ack[1] = 1'b1;
        tick();
        flush_ack[1] = 1'b0;
        settle();
        check("R10", "flush cleared", 32'(flush_req), 0);
        check("R10", "queue emptied", 32'(wp_valid), 0);
        tick();
        settle();
        check("R10", "queue stays empty", 32'(wp_valid), 0);

        // recovery: a fresh message is delivered normally
        tick();
        drive(2, 1'b1, 2'd1, 16'h8200);
        settle();
        check("R10", "ready after recovery", 32'(inj_ready[2]), 1);
        tick();
        drive(2, 1'b0, '0, '0);
        tick();
        settle();
        check("R10", "delivery after recovery", 32'(wp_valid), 32'b0010);
        check("R10", "data after recovery", 32'(port_data(1)), 32'h8200);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule